// File: doc/BRIEF.md
# Loadable Sum-of-Products Logic Array

This block evaluates a set of Boolean functions held as a two-plane personality matrix. An input plane defines a number of product terms. Each cell of a term's row says whether one input enters the term in true form, enters it complemented, or is left out. An output plane then connects terms to outputs. Each output is the OR of the terms wired to it. A single term can feed any number of outputs, so common sub-expressions are stored only once.

The matrix is loaded one term at a time through a synchronous write port. Each write carries a term number, that term's whole input-plane row and its whole output-plane row. The outputs are pure combinational logic of the current inputs and the stored matrix. After reset the matrix is empty. The default geometry is 3 inputs, 5 terms and 4 outputs, and all three are parameters.

Top module: `pla_array`

## Requirements
- R1: An input-plane cell holding 2'b01 makes its input appear uncomplemented in the term. Cell k of a row sits at bits [2k+1:2k] of the row, and input k is in_i[k].
- R2: An input-plane cell holding 2'b10 makes its input appear complemented in the term.
- R3: An input-plane cell holding 2'b00 leaves its input out of the term. A term whose cells are all 2'b00 evaluates to 1.
- R4: An input-plane cell holding 2'b11 forces its term to 0 for every input value.
- R5: Output j is the OR of every term whose output-plane bit j is 1. An output with no connected term is 0.
- R6: One term whose output-plane row has several bits set drives all of those outputs.
- R7: A write with cfg_we_i high replaces both the input-plane row and the output-plane row of term cfg_idx_i. The outputs reflect the new row from the first rising clock edge that samples the write, and not before.
- R8: A write whose cfg_idx_i is not below NUM_TERMS changes no stored row, so the outputs keep their values.
- R9: Asserting rst_ni low clears the whole matrix. All outputs are then 0 for every input value.
- R10: The outputs follow in_i combinationally, with no clock edge needed.
- R11: Suppose the array is loaded with terms AB, B'C, AC', B'C' and A, where A=in_i[0], B=in_i[1] and C=in_i[2]. The outputs are then out_o[0]=A+B'C', out_o[1]=AC'+AB, out_o[2]=B'C'+AB and out_o[3]=B'C+A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for configuration writes |
| rst_ni | input | 1 | Asynchronous active-low reset; empties the matrix |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Term number being written |
| cfg_and_i | input | 2*NUM_IN | Input-plane row; 2 bits per input |
| cfg_or_i | input | NUM_OUT | Output-plane row; bit j connects the term to output j |
| in_i | input | NUM_IN | Function inputs |
| out_o | output | NUM_OUT | Function outputs |

## Verification
The hardest case to reach from the ports is a write that must leave the array untouched. With the default five terms, the 3-bit index also encodes 5, 6 and 7. A stray decode of those values would corrupt a real row, and that row only shows the damage under some inputs. The bench first loads the full reference matrix. It then issues writes to every out-of-range index with rows that would switch every output on, and afterwards re-walks all eight input combinations against the reference truth table. The exact edge at which a write takes effect is probed by sampling the outputs both before and after that edge.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Input-plane cell encoding
  typedef enum logic [1:0] {
    CELL_SKIP = 2'b00,
    CELL_TRUE = 2'b01,
    CELL_INV  = 2'b10,
    CELL_KILL = 2'b11
  } cell_e;

  localparam int unsigned CELL_W = 2;
endpackage

// File: rtl/pla_term_row.sv
module pla_term_row
  import pla_pkg::*;
#(
  parameter int unsigned NUM_IN  = 3,
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned ROW_ID  = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [CELL_W*NUM_IN-1:0] and_i,
  input  logic [NUM_OUT-1:0]       or_i,
  input  logic [NUM_IN-1:0]        in_i,
  output logic                     term_o,
  output logic [NUM_OUT-1:0]       conn_o
);
  localparam int unsigned ROW_W = CELL_W * NUM_IN;

  logic [ROW_W-1:0]   and_q;
  logic [NUM_OUT-1:0] or_q;
  logic               hit;
  logic [NUM_IN-1:0]  cell_ok;

  assign hit = we_i && (idx_i == IDX_W'(ROW_ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      and_q <= '0;
      or_q  <= '0;
    end else if (hit) begin
      and_q <= and_i;
      or_q  <= or_i;
    end
  end

  for (genvar k = 0; k < NUM_IN; k++) begin : g_cell
    always_comb begin
      unique case (cell_e'(and_q[CELL_W*k +: CELL_W]))
        CELL_SKIP: cell_ok[k] = 1'b1;
        CELL_TRUE: cell_ok[k] = in_i[k];
        CELL_INV:  cell_ok[k] = ~in_i[k];
        default:   cell_ok[k] = 1'b0;
      endcase
    end
  end

  assign term_o = &cell_ok;
  assign conn_o = or_q;

  AST_ROW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (and_q == $past(and_i)) && (or_q == $past(or_i))); // R7
  AST_ROW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(and_q) && $stable(or_q)); // R8
  AST_EMPTY_ROW_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (and_q == '0) |-> term_o); // R3
  AST_KILL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((and_q & (and_q >> 1) & {NUM_IN{2'b01}}) != '0) |-> !term_o); // R4
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned NUM_TERMS = 5,
  parameter int unsigned NUM_OUT   = 4
) (
  input  logic [NUM_TERMS-1:0]              term_i,
  input  logic [NUM_TERMS-1:0][NUM_OUT-1:0] conn_i,
  output logic [NUM_OUT-1:0]                out_o
);
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    logic [NUM_TERMS-1:0] col;
    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_col
      assign col[t] = conn_i[t][j];
    end
    assign out_o[j] = |(term_i & col);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned NUM_IN    = 3,
  parameter int unsigned NUM_TERMS = 5,
  parameter int unsigned NUM_OUT   = 4,
  localparam int unsigned IDX_W    = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [IDX_W-1:0]         cfg_idx_i,
  input  logic [CELL_W*NUM_IN-1:0] cfg_and_i,
  input  logic [NUM_OUT-1:0]       cfg_or_i,
  input  logic [NUM_IN-1:0]        in_i,
  output logic [NUM_OUT-1:0]       out_o
);
  logic [NUM_TERMS-1:0]              term_v;
  logic [NUM_TERMS-1:0][NUM_OUT-1:0] conn_v;
  logic                              idx_oor;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_row
    pla_term_row #(
      .NUM_IN (NUM_IN),
      .NUM_OUT(NUM_OUT),
      .IDX_W  (IDX_W),
      .ROW_ID (t)
    ) u_row (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (cfg_we_i),
      .idx_i (cfg_idx_i),
      .and_i (cfg_and_i),
      .or_i  (cfg_or_i),
      .in_i  (in_i),
      .term_o(term_v[t]),
      .conn_o(conn_v[t])
    );
  end

  pla_or_plane #(
    .NUM_TERMS(NUM_TERMS),
    .NUM_OUT  (NUM_OUT)
  ) u_or (
    .term_i(term_v),
    .conn_i(conn_v),
    .out_o (out_o)
  );

  assign idx_oor = {1'b0, cfg_idx_i} >= (IDX_W+1)'(NUM_TERMS);

  AST_OOR_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && idx_oor) |=> ($stable(in_i) -> $stable(out_o))); // R8
  AST_OUT_NEEDS_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o != '0) |-> (term_v != '0)); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (out_o == '0)); // R9
endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3, NT = 5, NO = 4, IW = 3;

  // index = {C,B,A}, value = {F3,F2,F1,F0}
  localparam logic [3:0] REF_TBL [8] = '{4'h5, 4'hF, 4'h0, 4'hF, 4'h8, 4'h9, 4'h0, 4'hF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [2*NI-1:0] and_r = '0;
  logic [NO-1:0] or_r = '0;
  logic [NI-1:0] in_v = '0;
  logic [NO-1:0] out_v;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array #(.NUM_IN(NI), .NUM_TERMS(NT), .NUM_OUT(NO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_and_i(and_r), .cfg_or_i(or_r), .in_i(in_v), .out_o(out_v)
  );

  task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out=%h expected %h (in=%b)", req, act, exp, in_v);
    end
  endtask

  task automatic cfg_write(input logic [IW-1:0] i, input logic [2*NI-1:0] a, input logic [NO-1:0] o);
    @(negedge clk);
    we = 1'b1; idx = i; and_r = a; or_r = o;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic load_ref();
    cfg_write(3'd0, 6'b00_01_01, 4'b0110); // AB
    cfg_write(3'd1, 6'b01_10_00, 4'b1000); // B'C
    cfg_write(3'd2, 6'b10_00_01, 4'b0010); // AC'
    cfg_write(3'd3, 6'b10_10_00, 4'b0101); // B'C'
    cfg_write(3'd4, 6'b00_00_01, 4'b1001); // A
  endtask

  task automatic walk_ref(input string req);
    for (int v = 0; v < 8; v++) begin
      in_v = 3'(v); #1;
      check(req, out_v, REF_TBL[v]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: out=%h expected completion", out_v);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R9 empty after reset
    in_v = 3'b000; #1; check("R9", out_v, 4'h0);
    in_v = 3'b111; #1; check("R9", out_v, 4'h0);

    // R7 write timing, R3 all-skip term is 1
    @(negedge clk);
    we = 1'b1; idx = 3'd0; and_r = 6'b00_00_00; or_r = 4'b0001;
    #1; check("R7 before edge", out_v, 4'h0);
    @(posedge clk); #1; we = 1'b0;
    check("R7 after edge", out_v, 4'h1);
    in_v = 3'b010; #1; check("R3", out_v, 4'h1);

    // R1 true cell on A
    cfg_write(3'd0, 6'b00_00_01, 4'b0001);
    in_v = 3'b000; #1; check("R1", out_v, 4'h0);
    in_v = 3'b001; #1; check("R1", out_v, 4'h1);
    // R2 complement cell on A
    cfg_write(3'd0, 6'b00_00_10, 4'b0001);
    in_v = 3'b000; #1; check("R2", out_v, 4'h1);
    in_v = 3'b001; #1; check("R2", out_v, 4'h0);
    // R4 kill cell
    cfg_write(3'd0, 6'b00_11_00, 4'b0001);
    in_v = 3'b000; #1; check("R4", out_v, 4'h0);
    in_v = 3'b111; #1; check("R4", out_v, 4'h0);
    // R6 one term to all outputs
    cfg_write(3'd0, 6'b01_00_00, 4'b1111);
    in_v = 3'b100; #1; check("R6", out_v, 4'hF);
    in_v = 3'b011; #1; check("R6", out_v, 4'h0);
    // R5 term active but unconnected
    cfg_write(3'd0, 6'b00_00_00, 4'b0000);
    in_v = 3'b101; #1; check("R5", out_v, 4'h0);

    // R11 reference matrix, R10 inputs swept with no clocked write
    do_reset();
    load_ref();
    walk_ref("R11");
    @(negedge clk); in_v = 3'b001; #1; check("R10", out_v, 4'hF);
    in_v = 3'b110; #1; check("R10", out_v, 4'h0);

    // R8 out-of-range writes
    for (int i = NT; i < 8; i++) cfg_write(3'(i), 6'b00_00_00, 4'b1111);
    walk_ref("R8");

    // R9 reset after load
    do_reset();
    for (int v = 0; v < 8; v++) begin
      in_v = 3'(v); #1; check("R9 after load", out_v, 4'h0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule